// File: doc/BRIEF.md
# Interrupt Flag Controller

This block gathers four interrupt causes for a small processor core and turns them into one vector request. The causes are an edge on bit 0 of an 8-bit input port, a one-cycle timer-overflow pulse, a change on any of the port's upper four bits, and a one-cycle pulse that reports that a nonvolatile write has completed. Each cause sets a sticky flag. A flag raises a request only when its own enable bit and the global enable bit are both set.

Software reaches the flags and enables through a small register port with two addresses. When the block issues a vector request, it clears the global enable in the same clock, so the handler runs with requests masked. A return-from-interrupt strobe sets the global enable again. Hardware never clears a flag, so a handler that leaves a flag set is entered again as soon as it returns. The port pins are asynchronous and go through a synchronizer before any edge or change is detected.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag, every enable and the global enable read 0. `vec_req` is low and `vec_addr` is 0x000.
- R2: Bit 0 of `port_in` sets the external flag (control bit 1). When `ext_rise_sel`=1 only a 0-to-1 change sets it, and when `ext_rise_sel`=0 only a 1-to-0 change sets it. The flag reads back set 3 clocks after the pin changes.
- R3: A change on any of `port_in[7:4]` sets the port-change flag (control bit 0) 3 clocks later. A change on `port_in[3:1]` sets no flag.
- R4: A `tmr_ovf` pulse sets the timer flag (control bit 2) at the next clock. An `nvw_done` pulse sets the write-complete flag (auxiliary bit 4) at the next clock.
- R5: Hardware never clears a flag, and taking the vector does not clear one either. Software clears a flag by writing 0 to it. If a flag is set by hardware in the same clock as a software write of 0, the flag stays set.
- R6: `vec_req` pulses high for exactly one clock. It goes high one clock after some flag and its enable are both set while the global enable (control bit 7) is set. The enables are: port-change at control bit 3, external at bit 4, timer at bit 5, write-complete at bit 6. With the global enable at 0, or with no enabled flag, `vec_req` stays low.
- R7: In the clock where `vec_req` is high, the global enable reads 0.
- R8: A `reti` strobe sets the global enable at the next clock. If an enabled flag is still set, `vec_req` fires again one clock later.
- R9: `vec_addr` is 0x004 while `vec_req` is high and 0x000 otherwise.
- R10: `reg_sel`=0 selects the control register and `reg_sel`=1 selects the auxiliary register. In the auxiliary register only bit 4 is stored. Its other bits read 0 and ignore writes. `reg_rdata` shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | Asynchronous input port pins |
| ext_rise_sel | input | 1 | 1: external edge is rising, 0: falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| nvw_done | input | 1 | Nonvolatile write complete pulse |
| reg_sel | input | 1 | 0: control register, 1: auxiliary register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_req | output | 1 | One-cycle vector request |
| vec_addr | output | 12 | Vector address |

## Verification
The external input is driven with rising and falling pin changes under both polarity settings. This separates the selected edge from the opposite one. The port-change detector gets edits that touch only bits 3..1 and edits that touch bits 7..4, which shows whether the watched nibble is the right one. Requests are tried with the global enable clear and with it set, with a flag left set across a return, and with a software clear landing in the same clock as a timer pulse. These cases separate gating, retriggering and set-over-clear priority.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   localparam int REG_W   = 8;
   // control register bit positions
   localparam int FLG_CHG = 0;
   localparam int FLG_EXT = 1;
   localparam int FLG_TMR = 2;
   localparam int EN_CHG  = 3;
   localparam int EN_EXT  = 4;
   localparam int EN_TMR  = 5;
   localparam int EN_NVW  = 6;
   localparam int EN_GLB  = 7;
   // auxiliary register bit position
   localparam int AUX_NVW = 4;

   typedef struct packed {
      logic chg;
      logic ext;
      logic tmr;
      logic nvw;
   } src_evt_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W       = 8,
   parameter int STAGES  = 2,
   parameter bit SYNC_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (SYNC_EN) begin : g_sync
         logic [STAGES-1:0][W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end else begin : g_bypass
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
   parameter int W       = 8,
   parameter int EXT_BIT = 0,
   parameter int CHG_LO  = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic         rise_sel,
   output logic         ext_evt,
   output logic         chg_evt
);
   localparam int CHG_W = W - CHG_LO;

   logic             prev_ext;
   logic [CHG_W-1:0] prev_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ext <= 1'b0;
         prev_chg <= '0;
      end else begin
         prev_ext <= cur[EXT_BIT];
         prev_chg <= cur[W-1:CHG_LO];
      end
   end

   assign ext_evt = rise_sel ? (!prev_ext &&  cur[EXT_BIT])
                             : ( prev_ext && !cur[EXT_BIT]);
   assign chg_evt = |(cur[W-1:CHG_LO] ^ prev_chg);

   generate
      if (CHG_LO > EXT_BIT + 1) begin : g_gap
         logic unused_gap;
         assign unused_gap = ^cur[CHG_LO-1:EXT_BIT+1];
      end
      if (EXT_BIT > 0) begin : g_low
         logic unused_low;
         assign unused_low = ^cur[EXT_BIT-1:0];
      end
   endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irq_flag_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  src_evt_t         evt,
   input  logic             reg_sel,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             reti,
   input  logic             take,
   output logic [REG_W-1:0] ctrl_q,
   output logic             aux_nvw,
   output logic [REG_W-1:0] rdata,
   output logic             pending
);
   logic [REG_W-1:0] ctrl_d;
   logic             aux_d;

   always_comb begin
      ctrl_d = ctrl_q;
      aux_d  = aux_nvw;
      if (reg_wr && !reg_sel) ctrl_d = reg_wdata;
      if (reg_wr &&  reg_sel) aux_d  = reg_wdata[AUX_NVW];
      // hardware set wins over a same-cycle software clear
      if (evt.chg) ctrl_d[FLG_CHG] = 1'b1;
      if (evt.ext) ctrl_d[FLG_EXT] = 1'b1;
      if (evt.tmr) ctrl_d[FLG_TMR] = 1'b1;
      if (evt.nvw) aux_d           = 1'b1;
      if (reti)    ctrl_d[EN_GLB]  = 1'b1;
      if (take)    ctrl_d[EN_GLB]  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         aux_nvw <= 1'b0;
      end else begin
         ctrl_q  <= ctrl_d;
         aux_nvw <= aux_d;
      end
   end

   always_comb begin
      rdata = '0;
      if (reg_sel) rdata[AUX_NVW] = aux_nvw;
      else         rdata = ctrl_q;
   end

   assign pending = (ctrl_q[FLG_CHG] && ctrl_q[EN_CHG])
                 || (ctrl_q[FLG_EXT] && ctrl_q[EN_EXT])
                 || (ctrl_q[FLG_TMR] && ctrl_q[EN_TMR])
                 || (aux_nvw         && ctrl_q[EN_NVW]);
endmodule

// File: rtl/irq_vec.sv
module irq_vec #(
   parameter int               VEC_W   = 12,
   parameter logic [VEC_W-1:0] VEC_IRQ = 12'h004,
   parameter logic [VEC_W-1:0] VEC_RST = 12'h000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   output logic             vec_req,
   output logic [VEC_W-1:0] vec_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_req <= 1'b0;
      else        vec_req <= take;
   end
   assign vec_addr = vec_req ? VEC_IRQ : VEC_RST;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_flag_pkg::*;
#(
   parameter int               PORT_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter bit               SYNC_EN     = 1'b1,
   parameter int               EXT_BIT     = 0,
   parameter int               CHG_LO      = 4,
   parameter int               VEC_W       = 12,
   parameter logic [VEC_W-1:0] VEC_IRQ     = 12'h004,
   parameter logic [VEC_W-1:0] VEC_RST     = 12'h000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_in,
   input  logic              ext_rise_sel,
   input  logic              tmr_ovf,
   input  logic              nvw_done,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              reti,
   output logic              vec_req,
   output logic [VEC_W-1:0]  vec_addr
);
   generate
      if (SYNC_STAGES < 2)       begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (CHG_LO >= PORT_W)      begin : g_bad_chg  $error("CHG_LO must lie inside the port"); end
      if (EXT_BIT >= CHG_LO)     begin : g_bad_ext  $error("EXT_BIT must lie below CHG_LO"); end
      if (VEC_IRQ == VEC_RST)    begin : g_bad_vec  $error("vectors must differ"); end
   endgenerate

   logic [PORT_W-1:0] port_s;
   logic              ext_evt, chg_evt, pending, take;
   logic [REG_W-1:0]  ctrl_q;
   logic              aux_nvw;
   src_evt_t          evt;

   irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .SYNC_EN(SYNC_EN)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s));

   irq_detect #(.W(PORT_W), .EXT_BIT(EXT_BIT), .CHG_LO(CHG_LO)) u_det (
      .clk(clk), .rst_n(rst_n), .cur(port_s), .rise_sel(ext_rise_sel),
      .ext_evt(ext_evt), .chg_evt(chg_evt));

   assign evt = '{chg: chg_evt, ext: ext_evt, tmr: tmr_ovf, nvw: nvw_done};

   irq_regs u_regs (
      .clk(clk), .rst_n(rst_n), .evt(evt), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reti(reti), .take(take), .ctrl_q(ctrl_q),
      .aux_nvw(aux_nvw), .rdata(reg_rdata), .pending(pending));

   assign take = ctrl_q[EN_GLB] && pending;

   irq_vec #(.VEC_W(VEC_W), .VEC_IRQ(VEC_IRQ), .VEC_RST(VEC_RST)) u_vec (
      .clk(clk), .rst_n(rst_n), .take(take), .vec_req(vec_req), .vec_addr(vec_addr));
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reti,
   input logic       reg_wr,
   input logic       reg_sel,
   input logic       vec_req,
   input logic [7:0] ctrl_q,
   input logic       aux_nvw
);
   logic ctl_wr, aux_wr;
   assign ctl_wr = reg_wr && !reg_sel;
   assign aux_wr = reg_wr &&  reg_sel;

   AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n) vec_req |-> !ctrl_q[7]); // R7
   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) vec_req |=> !vec_req); // R6
   AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_q[7] |=> !vec_req); // R6
   AST_RETI_UNMASK: assert property (@(posedge clk) disable iff (!rst_n) (reti && !ctrl_q[7]) |=> ctrl_q[7]); // R8
   AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[0] && !ctl_wr) |=> ctrl_q[0]); // R5
   AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[1] && !ctl_wr) |=> ctrl_q[1]); // R5
   AST_TMR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[2] && !ctl_wr) |=> ctrl_q[2]); // R5
   AST_NVW_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (aux_nvw && !aux_wr) |=> aux_nvw); // R5
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reti(reti), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .vec_req(vec_req), .ctrl_q(ctrl_q), .aux_nvw(aux_nvw));

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  port_in = '0;
   logic        ext_rise_sel = 1'b1;
   logic        tmr_ovf = 1'b0, nvw_done = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0, reti = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        vec_req;
   logic [11:0] vec_addr;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_flag_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .port_in(port_in), .ext_rise_sel(ext_rise_sel),
      .tmr_ovf(tmr_ovf), .nvw_done(nvw_done), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reti(reti),
      .vec_req(vec_req), .vec_addr(vec_addr));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, updated on every rising edge
   logic [7:0] m_s1, m_s2, m_pv, m_ctl;
   logic       m_aux, m_vec;
   always @(posedge clk) begin
      logic ext_e, chg_e, pend, tk;
      logic [7:0] nctl;
      logic naux;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_pv = 0; m_ctl = 0; m_aux = 0; m_vec = 0;
      end else begin
         ext_e = ext_rise_sel ? (m_pv[0] == 1'b0 && m_s2[0] == 1'b1)
                              : (m_pv[0] == 1'b1 && m_s2[0] == 1'b0);
         chg_e = (m_s2[7:4] != m_pv[7:4]);
         pend  = (m_ctl[0] & m_ctl[3]) | (m_ctl[1] & m_ctl[4]) |
                 (m_ctl[2] & m_ctl[5]) | (m_aux & m_ctl[6]);
         tk    = m_ctl[7] & pend;
         nctl = m_ctl; naux = m_aux;
         if (reg_wr && !reg_sel) nctl = reg_wdata;
         if (reg_wr && reg_sel)  naux = reg_wdata[4];
         if (chg_e)    nctl[0] = 1'b1;
         if (ext_e)    nctl[1] = 1'b1;
         if (tmr_ovf)  nctl[2] = 1'b1;
         if (nvw_done) naux = 1'b1;
         if (reti)     nctl[7] = 1'b1;
         if (tk)       nctl[7] = 1'b0;
         m_ctl = nctl; m_aux = naux; m_vec = tk;
         m_pv = m_s2; m_s2 = m_s1; m_s1 = port_in;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 vec_req model", {15'd0, vec_req}, {15'd0, m_vec});
         chk("R9 vec_addr model", {4'd0, vec_addr}, m_vec ? 16'h0004 : 16'h0000);
         chk("R10 rdata model", {8'd0, reg_rdata},
             reg_sel ? {8'd0, 3'b000, m_aux, 4'b0000} : {8'd0, m_ctl});
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
      tick(1);
      reg_wr = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic rd(input string tag, input logic sel, input logic [7:0] exp);
      reg_sel = sel; #1;
      chk(tag, {8'd0, reg_rdata}, {8'd0, exp});
      reg_sel = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd("R1 ctrl after reset", 1'b0, 8'h00);
      rd("R1 aux after reset", 1'b1, 8'h00);
      chk("R1 vec_req after reset", {15'd0, vec_req}, 16'd0);
      chk("R1 vec_addr after reset", {4'd0, vec_addr}, 16'h0000);

      // R4 timer flag, R5 stays set, R6 no request without enables
      tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
      rd("R4 timer flag set", 1'b0, 8'h04);
      tick(3);
      rd("R5 timer flag sticky", 1'b0, 8'h04);
      chk("R6 no request when disabled", {15'd0, vec_req}, 16'd0);
      wr(1'b0, 8'h00);
      rd("R5 software clear", 1'b0, 8'h00);

      // R2 rising mode
      ext_rise_sel = 1'b1;
      port_in = 8'h01; tick(3);
      rd("R2 rising edge sets flag", 1'b0, 8'h02);
      wr(1'b0, 8'h00);
      port_in = 8'h00; tick(4);
      rd("R2 falling ignored in rising mode", 1'b0, 8'h00);

      // R2 falling mode
      ext_rise_sel = 1'b0;
      port_in = 8'h01; tick(4);
      rd("R2 rising ignored in falling mode", 1'b0, 8'h00);
      port_in = 8'h00; tick(3);
      rd("R2 falling edge sets flag", 1'b0, 8'h02);
      wr(1'b0, 8'h00);
      ext_rise_sel = 1'b1;

      // R3 nibble watch
      port_in = 8'h0E; tick(4);
      rd("R3 low bits ignored", 1'b0, 8'h00);
      port_in = 8'h4E; tick(3);
      rd("R3 upper nibble change", 1'b0, 8'h01);
      wr(1'b0, 8'h00);

      // R4 / R10 auxiliary register
      nvw_done = 1'b1; tick(1); nvw_done = 1'b0;
      rd("R4 write-complete flag", 1'b1, 8'h10);
      wr(1'b1, 8'hEF);
      rd("R10 aux unused bits ignore writes", 1'b1, 8'h00);
      rd("R10 ctrl untouched by aux write", 1'b0, 8'h00);

      // R6 R7 R9 vector take
      wr(1'b0, 8'hA0);
      tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
      chk("R6 no request before flag seen", {15'd0, vec_req}, 16'd0);
      tick(1);
      chk("R6 request issued", {15'd0, vec_req}, 16'd1);
      chk("R9 irq vector", {4'd0, vec_addr}, 16'h0004);
      rd("R7 global enable cleared, flag kept", 1'b0, 8'h24);
      tick(1);
      chk("R6 single pulse", {15'd0, vec_req}, 16'd0);
      chk("R9 rest vector", {4'd0, vec_addr}, 16'h0000);

      // R8 return with flag still set
      reti = 1'b1; tick(1); reti = 1'b0;
      rd("R8 global enable restored", 1'b0, 8'hA4);
      tick(1);
      chk("R8 retrigger", {15'd0, vec_req}, 16'd1);
      tick(1);
      wr(1'b0, 8'h20);
      reti = 1'b1; tick(1); reti = 1'b0;
      tick(2);
      chk("R8 no retrigger after clear", {15'd0, vec_req}, 16'd0);

      // R5 set wins over same-cycle clear
      reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 8'hA0; tmr_ovf = 1'b1;
      tick(1);
      reg_wr = 1'b0; tmr_ovf = 1'b0;
      rd("R5 set beats clear", 1'b0, 8'hA4);
      tick(1);
      chk("R6 request after collision", {15'd0, vec_req}, 16'd1);
      tick(1);

      // R6 global enable set but source enable clear
      wr(1'b0, 8'h80);
      nvw_done = 1'b1; tick(1); nvw_done = 1'b0;
      tick(3);
      chk("R6 source enable gates", {15'd0, vec_req}, 16'd0);
      tick(2);
      finish_run();
   end
endmodule